// File: doc/BRIEF.md
# Nine-Bit Serial Display Link

This block carries display commands and their parameter or pixel bytes to a panel controller that expects nine-bit serial words. Each word received on a valid/ready input stream holds a payload byte, a data/command flag and an end-of-transfer marker. In serial mode the block drives an active-low chip select, a serial clock and a serial data line. It shifts the flag out first and then the byte, most significant bit first. Chip select stays low from the first word of a transfer until the word marked last has been sent.

Some hosts can only move whole bytes. For them a packed mode collects eight nine-bit words into one 72-bit group and presents it as nine bytes on a byte-stream output, with no gaps between words. A configuration input selects packed mode and overrides the native serial path. The selected mode is taken up only between transfers. If a transfer ends before a group is full, the group is filled out with no-op words: payload 0x00 with the flag clear.

The serial engine has five states. `N_IDLE`: chip select is high and a word may be taken. `N_LOW`: the clock is low for one half period. `N_HIGH`: the clock is high for one half period. `N_WAIT`: chip select is held low between the words of a transfer. `N_TAIL`: a final low half period runs before chip select is released. Its transitions are:
- `start` (N_IDLE or N_WAIT to N_LOW, on accepting a word)
- `rise` (N_LOW to N_HIGH)
- `next_bit` (N_HIGH to N_LOW)
- `word_done` (N_HIGH to N_WAIT, when the word is not last)
- `end_xfer` (N_HIGH to N_TAIL, when the word is last)
- `release` (N_TAIL to N_IDLE)

The packer has three states. `P_FILL` takes words. `P_PAD` inserts no-op words. `P_SEND` emits the group bytes. Its transitions are:
- `group_full` (P_FILL to P_SEND, on the eighth word)
- `short_end` (P_FILL to P_PAD, on a last word before the eighth)
- `pad_full` (P_PAD to P_SEND)
- `group_sent` (P_SEND to P_FILL, after the ninth byte is taken)

Top module: `ser9_link`

## Requirements
- R1: After reset, ser_cs_n is 1, ser_clk is 0, pk_valid is 0 and in_ready is 1.
- R2: In serial mode each accepted word produces exactly nine rising edges of ser_clk. At those edges ser_dat carries, in order, the flag (0 = command, 1 = parameter/pixel) and then payload bits 7 down to 0.
- R3: ser_dat never changes while ser_clk stays high. Every high phase of ser_clk, and every low phase inside a word, lasts cfg_div+1 system clock cycles.
- R4: ser_clk only rises while ser_cs_n is 0. ser_cs_n stays 0 between the words of one transfer. It returns to 1 only after all nine bits of the word marked last have been sent.
- R5: in_ready is 0 while a serial word is shifting, so every accepted word appears on the serial line in order and none is lost.
- R6: In packed mode every eight words form a 72-bit group. The first word's flag is bit 71, and each word occupies 9 bits, flag first and payload most significant bit first. The group is emitted as nine bytes, group bits 71:64 first.
- R7: A last word that arrives before a group is full causes the group to be completed with words of value 0x00 and flag 0. pk_last is 1 only on the ninth byte of the group holding the last word.
- R8: While packed mode is in effect, the serial pins stay idle (ser_cs_n 1, no ser_clk edge). A change of cfg_packed during an open transfer takes effect only after that transfer ends.
- R9: While pk_valid is 1 and pk_ready is 0, pk_valid stays 1 and pk_byte keeps its value.
- R10: in_ready is 0 while packed bytes are being offered on the byte output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_packed | input | 1 | 1 selects packed byte-stream mode |
| cfg_div | input | DIV_W | Serial half period in system cycles, minus one |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_dc | input | 1 | Flag: 0 command, 1 parameter/pixel |
| in_byte | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final word of a transfer |
| ser_cs_n | output | 1 | Serial chip select, active low |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_dat | output | 1 | Serial data, changes on the falling edge |
| pk_valid | output | 1 | Packed byte valid |
| pk_ready | input | 1 | Packed byte taken when high with pk_valid |
| pk_byte | output | 8 | Packed byte |
| pk_last | output | 1 | Final byte of the final group of a transfer |

## Verification
The hardest situation to reach is a change of cfg_packed while a serial transfer is still open. There the block must finish the transfer on the serial pins before it switches. The bench flips cfg_packed between two words of an unfinished transfer and expects the remaining words on the serial line. Short packed transfers of one, seven and eight words exercise padding and the full-group boundary. Random stalls on pk_ready hold bytes under backpressure. Half periods of one, two and four cycles are used to check the phase lengths.

// File: rtl/ser9_pkg.sv
package ser9_pkg;
    localparam int PAY_W     = 8;
    localparam int WORD_W    = PAY_W + 1;
    localparam int GRP_WORDS = 8;
    localparam int GRP_BITS  = GRP_WORDS * WORD_W;
    localparam int GRP_BYTES = GRP_BITS / PAY_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        N_IDLE,
        N_WAIT,
        N_LOW,
        N_HIGH,
        N_TAIL
    } nat_state_t;

    typedef enum logic [1:0] {
        P_FILL,
        P_PAD,
        P_SEND
    } pk_state_t;
endpackage

// File: rtl/ser9_native.sv
module ser9_native
    import ser9_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             w_valid,
    output logic             w_ready,
    input  word_t            w_word,
    input  logic             w_last,
    output logic             cs_n,
    output logic             sclk,
    output logic             sdat,
    output logic             idle
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    nat_state_t       state, nxt;
    logic [DIV_W-1:0] divcnt;
    logic [CNT_W-1:0] bitcnt;
    word_t            sh;
    logic             last_q;
    logic             phase_done;

    assign phase_done = (divcnt == cfg_div);
    assign w_ready    = (state == N_IDLE) || (state == N_WAIT);
    assign idle       = (state == N_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= N_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            N_IDLE, N_WAIT: if (w_valid) nxt = N_LOW;
            N_LOW:          if (phase_done) nxt = N_HIGH;
            N_HIGH: begin
                if (phase_done) begin
                    if (bitcnt != LAST_BIT) nxt = N_LOW;
                    else if (last_q)        nxt = N_TAIL;
                    else                    nxt = N_WAIT;
                end
            end
            N_TAIL:         if (phase_done) nxt = N_IDLE;
            default:        nxt = N_IDLE;
        endcase
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n   <= 1'b1;
            sclk   <= 1'b0;
            sdat   <= 1'b0;
            sh     <= '0;
            bitcnt <= '0;
            divcnt <= '0;
            last_q <= 1'b0;
        end else begin
            unique case (state)
                N_IDLE, N_WAIT: begin
                    if (w_valid) begin
                        cs_n   <= 1'b0;
                        sdat   <= w_word[WORD_W-1];
                        sh     <= {w_word[WORD_W-2:0], 1'b0};
                        bitcnt <= '0;
                        divcnt <= '0;
                        last_q <= w_last;
                    end
                end
                N_LOW: begin
                    if (phase_done) begin
                        sclk   <= 1'b1;
                        divcnt <= '0;
                    end else begin
                        divcnt <= divcnt + 1'b1;
                    end
                end
                N_HIGH: begin
                    if (phase_done) begin
                        sclk   <= 1'b0;
                        divcnt <= '0;
                        if (bitcnt != LAST_BIT) begin
                            sdat   <= sh[WORD_W-1];
                            sh     <= {sh[WORD_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end else begin
                        divcnt <= divcnt + 1'b1;
                    end
                end
                N_TAIL: begin
                    if (phase_done) begin
                        cs_n   <= 1'b1;
                        divcnt <= '0;
                    end else begin
                        divcnt <= divcnt + 1'b1;
                    end
                end
                default: begin
                    cs_n <= 1'b1;
                    sclk <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ser9_packer.sv
module ser9_packer
    import ser9_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             w_valid,
    output logic             w_ready,
    input  word_t            w_word,
    input  logic             w_last,
    output logic             pk_valid,
    input  logic             pk_ready,
    output logic [PAY_W-1:0] pk_byte,
    output logic             pk_last,
    output logic             idle
);
    localparam int WC_W = $clog2(GRP_WORDS);
    localparam int BC_W = $clog2(GRP_BYTES);
    localparam logic [WC_W-1:0] LAST_WORD = WC_W'(GRP_WORDS - 1);
    localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(GRP_BYTES - 1);

    pk_state_t           state, nxt;
    logic [GRP_BITS-1:0] gbuf;
    logic [WC_W-1:0]     wcnt;
    logic [BC_W-1:0]     bidx;
    logic                last_q;
    logic                take;

    assign take     = (state == P_FILL) && w_valid;
    assign w_ready  = (state == P_FILL);
    assign pk_valid = (state == P_SEND);
    assign pk_byte  = gbuf[GRP_BITS-1 -: PAY_W];
    assign pk_last  = (state == P_SEND) && last_q && (bidx == LAST_BYTE);
    assign idle     = (state == P_FILL) && (wcnt == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= P_FILL;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            P_FILL: begin
                if (take) begin
                    if (wcnt == LAST_WORD) nxt = P_SEND;
                    else if (w_last)       nxt = P_PAD;
                end
            end
            P_PAD:   if (wcnt == LAST_WORD) nxt = P_SEND;
            P_SEND:  if (pk_ready && bidx == LAST_BYTE) nxt = P_FILL;
            default: nxt = P_FILL;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gbuf   <= '0;
            wcnt   <= '0;
            bidx   <= '0;
            last_q <= 1'b0;
        end else begin
            unique case (state)
                P_FILL: begin
                    if (take) begin
                        gbuf <= {gbuf[GRP_BITS-WORD_W-1:0], w_word};
                        if (wcnt == LAST_WORD) begin
                            wcnt   <= '0;
                            bidx   <= '0;
                            last_q <= w_last;
                        end else begin
                            wcnt   <= wcnt + 1'b1;
                            last_q <= w_last;
                        end
                    end
                end
                P_PAD: begin
                    gbuf <= {gbuf[GRP_BITS-WORD_W-1:0], {WORD_W{1'b0}}};
                    if (wcnt == LAST_WORD) begin
                        wcnt <= '0;
                        bidx <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                P_SEND: begin
                    if (pk_ready) begin
                        gbuf <= {gbuf[GRP_BITS-PAY_W-1:0], {PAY_W{1'b0}}};
                        if (bidx == LAST_BYTE) begin
                            bidx   <= '0;
                            last_q <= 1'b0;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                end
                default: wcnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ser9_link.sv
module ser9_link
    import ser9_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_packed,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_dc,
    input  logic [PAY_W-1:0] in_byte,
    input  logic             in_last,
    output logic             ser_cs_n,
    output logic             ser_clk,
    output logic             ser_dat,
    output logic             pk_valid,
    input  logic             pk_ready,
    output logic [PAY_W-1:0] pk_byte,
    output logic             pk_last
);
    logic  mode_q;
    logic  xfer_open;
    logic  nat_ready, nat_idle;
    logic  pak_ready, pak_idle;
    logic  busy, mode_ok, accept;
    word_t word_in;

    assign word_in  = {in_dc, in_byte};
    assign busy     = xfer_open || !nat_idle || !pak_idle;
    assign mode_ok  = busy || (cfg_packed == mode_q);
    assign in_ready = mode_ok && (mode_q ? pak_ready : nat_ready);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            xfer_open <= 1'b0;
        end else begin
            if (!busy) mode_q <= cfg_packed;
            if (accept) xfer_open <= !in_last;
        end
    end

    ser9_native #(.DIV_W(DIV_W)) u_native (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_div (cfg_div),
        .w_valid (in_valid && mode_ok && !mode_q),
        .w_ready (nat_ready),
        .w_word  (word_in),
        .w_last  (in_last),
        .cs_n    (ser_cs_n),
        .sclk    (ser_clk),
        .sdat    (ser_dat),
        .idle    (nat_idle)
    );

    ser9_packer u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .w_valid  (in_valid && mode_ok && mode_q),
        .w_ready  (pak_ready),
        .w_word   (word_in),
        .w_last   (in_last),
        .pk_valid (pk_valid),
        .pk_ready (pk_ready),
        .pk_byte  (pk_byte),
        .pk_last  (pk_last),
        .idle     (pak_idle)
    );
endmodule

// File: rtl/ser9_link_chk.sv
module ser9_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       ser_cs_n,
    input logic       ser_clk,
    input logic       ser_dat,
    input logic       pk_valid,
    input logic       pk_ready,
    input logic [7:0] pk_byte
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (ser_cs_n && !ser_clk && !pk_valid));

    // R3
    data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> (ser_dat == $past(ser_dat)));

    // R4
    rise_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> !ser_cs_n);

    // R5
    no_take_while_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !ser_clk);

    // R8
    packed_serial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |-> ser_cs_n);

    // R9
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_valid && !pk_ready) |=> (pk_valid && $stable(pk_byte)));

    // R10
    no_take_while_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !pk_valid);
endmodule

bind ser9_link ser9_link_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .ser_cs_n (ser_cs_n),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .pk_valid (pk_valid),
    .pk_ready (pk_ready),
    .pk_byte  (pk_byte)
);

// File: tb/ser9_link_bench.sv
module ser9_link_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_packed = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             in_dc = 1'b0;
    logic [7:0]       in_byte = '0;
    logic             in_last = 1'b0;
    logic             ser_cs_n, ser_clk, ser_dat;
    logic             pk_valid, pk_last;
    logic             pk_ready = 1'b1;
    logic [7:0]       pk_byte;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit stall_en = 0;

    // expected serial words {last, flag, byte}
    logic [9:0] exp_nat[$];
    // pending packed words, expected packed bytes {last, byte}
    logic [8:0] pend[$];
    logic [8:0] exp_pk[$];

    int nat_words_seen = 0;
    int rises_total = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser9_link #(.DIV_W(DIV_W)) u_ser9_link (
        .clk(clk), .rst_n(rst_n), .cfg_packed(cfg_packed), .cfg_div(cfg_div),
        .in_valid(in_valid), .in_ready(in_ready), .in_dc(in_dc),
        .in_byte(in_byte), .in_last(in_last),
        .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_byte(pk_byte),
        .pk_last(pk_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // packed reference: group eight words, pad on last
    task automatic ref_pack(input logic [8:0] w, input bit last);
        logic [71:0] g;
        pend.push_back(w);
        if (pend.size() == 8 || last) begin
            while (pend.size() < 8) pend.push_back(9'h000);
            g = '0;
            for (int i = 0; i < 8; i++) g = {g[62:0], pend.pop_front()};
            for (int i = 0; i < 9; i++)
                exp_pk.push_back({(last && i == 8), g[71-8*i -: 8]});
        end
    endtask

    // drive one word; the expected path is chosen by the mode in effect
    task automatic send(input bit dc, input logic [7:0] b, input bit last,
                        input bit packed_path);
        @(posedge clk); #1;
        in_valid = 1'b1; in_dc = dc; in_byte = b; in_last = last;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        if (packed_path) ref_pack({dc, b}, last);
        else exp_nat.push_back({last, dc, b});
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while ((exp_nat.size() != 0 || exp_pk.size() != 0 || !ser_cs_n) && t < 20000) begin
            @(negedge clk); t++;
        end
        repeat (8) @(negedge clk);
    endtask

    // backpressure pattern on pk_ready
    initial begin
        logic [7:0] lfsr = 8'hA5;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pk_ready = stall_en ? lfsr[0] : 1'b1;
        end
    end

    // cycle-by-cycle behavioural monitor
    initial begin
        logic       p_clk = 1'b0, p_dat = 1'b0, p_cs = 1'b1;
        logic       p_pv = 1'b0, p_pr = 1'b1;
        logic [7:0] p_pb = '0;
        int         run = 0, bitn = 0;
        logic [8:0] acc = '0;
        bit         last_seen = 1'b1;
        logic [9:0] e;
        logic [8:0] eb;
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (ser_clk && !p_clk) begin
                    rises_total++;
                    check(!ser_cs_n, "R4", "clock rise with select high", ser_cs_n, 0);
                    if (bitn > 0)
                        check(run == int'(cfg_div) + 1, "R3", "low phase length", run, int'(cfg_div) + 1);
                    acc = {acc[7:0], ser_dat};
                    bitn++;
                    if (bitn == 9) begin
                        bitn = 0;
                        nat_words_seen++;
                        if (exp_nat.size() == 0) begin
                            check(0, "R5", "unexpected serial word", acc, 0);
                        end else begin
                            e = exp_nat.pop_front();
                            check(acc == e[8:0], "R2", "serial word", acc, e[8:0]);
                            last_seen = e[9];
                        end
                    end
                end
                if (!ser_clk && p_clk)
                    check(run == int'(cfg_div) + 1, "R3", "high phase length", run, int'(cfg_div) + 1);
                if (ser_clk && p_clk && ser_dat != p_dat)
                    check(0, "R3", "data moved while clock high", ser_dat, p_dat);
                if (ser_cs_n && !p_cs)
                    check(bitn == 0 && last_seen, "R4", "select released mid transfer",
                          {bitn, last_seen}, 1);
                if (ser_clk == p_clk) run++; else run = 1;

                if (p_pv && !p_pr)
                    check(pk_valid && pk_byte == p_pb, "R9", "byte held under stall",
                          {pk_valid, pk_byte}, {1'b1, p_pb});
                if (in_ready && pk_valid)
                    check(0, "R10", "ready while emitting", 1, 0);
                if (pk_valid && pk_ready) begin
                    if (exp_pk.size() == 0) begin
                        check(0, "R6", "unexpected packed byte", pk_byte, 0);
                    end else begin
                        eb = exp_pk.pop_front();
                        check(pk_byte == eb[7:0], "R6", "packed byte", pk_byte, eb[7:0]);
                        check(pk_last == eb[8], "R7", "packed last flag", pk_last, eb[8]);
                    end
                end
                p_clk = ser_clk; p_dat = ser_dat; p_cs = ser_cs_n;
                p_pv = pk_valid; p_pr = pk_ready; p_pb = pk_byte;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int r0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ser_cs_n == 1'b1, "R1", "cs_n after reset", ser_cs_n, 1);
        check(ser_clk == 1'b0, "R1", "sclk after reset", ser_clk, 0);
        check(pk_valid == 1'b0, "R1", "pk_valid after reset", pk_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

        // R2/R4: command with parameters, fastest clock
        cfg_div = 8'd0;
        send(0, 8'hC1, 0, 0);
        send(1, 8'hFF, 0, 0);
        send(1, 8'h83, 0, 0);
        send(1, 8'h40, 1, 0);
        drain();
        // R3: other half periods, single command then pixel data
        cfg_div = 8'd1;
        send(0, 8'h11, 1, 0);
        drain();
        cfg_div = 8'd3;
        send(0, 8'h2C, 0, 0);
        send(1, 8'h00, 0, 0);
        send(1, 8'hFF, 0, 0);
        send(1, 8'hA5, 1, 0);
        drain();
        check(nat_words_seen == 9, "R5", "serial words delivered", nat_words_seen, 9);

        // R8: mode change inside an open transfer waits for its end
        cfg_div = 8'd0;
        send(0, 8'h36, 0, 0);
        cfg_packed = 1'b1;
        send(1, 8'h68, 0, 0);
        send(1, 8'h5A, 1, 0);
        drain();
        check(nat_words_seen == 12, "R8", "late words stayed serial", nat_words_seen, 12);

        // R6/R7: packed mode, full group, short groups, stalls
        stall_en = 1'b1;
        r0 = rises_total;
        for (int i = 0; i < 8; i++) send(i != 0, 8'(8'h10 + i), i == 7, 1);
        drain();
        for (int i = 0; i < 11; i++) send(1, 8'(8'hE0 ^ (i * 7)), i == 10, 1);
        drain();
        send(0, 8'h29, 1, 1);
        drain();
        for (int i = 0; i < 7; i++) send(i[0], 8'(8'h3A + i), i == 6, 1);
        drain();
        check(rises_total == r0, "R8", "serial clock quiet in packed mode", rises_total, r0);
        check(ser_cs_n == 1'b1, "R8", "select idle in packed mode", ser_cs_n, 1);
        stall_en = 1'b0;

        // back to serial
        cfg_packed = 1'b0;
        send(0, 8'h00, 1, 0);
        drain();
        check(exp_nat.size() == 0, "R2", "serial queue empty", exp_nat.size(), 0);
        check(exp_pk.size() == 0, "R6", "packed queue empty", exp_pk.size(), 0);
        check(pend.size() == 0, "R7", "no partial group left", pend.size(), 0);
        done = 1;
        finish_run();
    end
endmodule